// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one frame of serial data at a time over three lines: a shift clock, a data input and a data output. It can run as the clock owner, in which case it makes the shift clock itself from the system clock through a programmable divider. It can also run as a follower, in which case it takes the shift clock from outside, brings it and the data input into the system clock domain, and reacts to their edges.

Each transfer is set up through a simple register-side interface. Software places a transmit word on `tx_data`, selects the mode, the bit order, the frame length (8 or 16 bits) and the clock divider, and pulses `start`. The port captures this configuration for the whole frame and raises `busy`. When the last bit has been sampled it drops `busy`, pulses `done` for one cycle and presents the received word, right-aligned, on `rx_data`. The shift clock idles high. Outgoing bits change on its falling edge and incoming bits are taken on its rising edge.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sck_out` and `sout` are 1, `busy` and `done` are 0 and `rx_data` is 0.
- R2: In clock-owner mode (`cfg_slave`=0), `sck_out` falls on the clock edge that accepts `start`. Its low and high phases then last `cfg_div`+1 system cycles each. It stays high whenever the port is not busy.
- R3: A frame has 8 shift-clock rising edges when `cfg_wide`=0 and 16 when `cfg_wide`=1.
- R4: With `cfg_msb_first`=0, `sout` carries bit 0 of the captured transmit word first and then the bits in rising index order. With `cfg_msb_first`=1 it starts from bit 7 (8-bit frame) or bit 15 (16-bit frame) and goes down. In clock-owner mode `sout` changes only together with a falling edge of `sck_out`.
- R5: Received bits are placed in the same order as the transmit bits. The word is right-aligned in `rx_data`, and bits 15..8 read 0 after an 8-bit frame.
- R6: The edge that samples the last bit clears `busy`, sets `done` for exactly one cycle and updates `rx_data`. `done` is never high while `busy` is high.
- R7: A `start` pulse while `busy` is high is ignored. The running frame continues with its original data and no new frame follows it.
- R8: Mode, bit order, frame length and divider are captured when `start` is accepted. Changes to them during a frame have no effect on that frame.
- R9: In follower mode (`cfg_slave`=1), `start` loads and arms the port. The port then samples `sin` on each rising edge of `sck_in` and advances `sout` on each falling edge, after a two-flop synchroniser on both inputs. `sck_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 1 = follower mode (external shift clock), 0 = clock-owner mode |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_div | input | 4 | Half-period of the generated shift clock, minus one, in system cycles |
| tx_data | input | 16 | Word to transmit, right-aligned |
| start | input | 1 | Start (clock-owner mode) or arm (follower mode) request |
| rx_data | output | 16 | Last received word, right-aligned |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| sck_out | output | 1 | Generated shift clock, idles high |
| sck_in | input | 1 | External shift clock for follower mode |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |

## Verification
The hardest case to reach is a `start` request, together with a different transmit word and a flipped configuration, arriving in the middle of a running frame. The stimulus fires such a request a few cycles after a frame has begun. It then confirms that the waveform, the received word and the idle state after `done` all follow the original frame. Follower mode is exercised by a bench-generated external clock that is slow compared with the system clock, with the data input changed on its falling edges. This lets the synchroniser latency be absorbed before each rising edge.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  // Width of a bit index inside a frame; supports frames of up to 32 bits.
  localparam int unsigned IDX_W = 5;
  typedef logic [IDX_W-1:0] idx_t;

  // Position in the data word of the idx-th bit on the wire.
  function automatic idx_t wire_pos(input idx_t idx, input logic msb_first, input idx_t last);
    return msb_first ? idx_t'(last - idx) : idx;
  endfunction

  // Index of the final bit of a frame for the chosen length.
  function automatic idx_t frame_last(input logic wide, input idx_t short_last, input idx_t long_last);
    return wide ? long_last : short_last;
  endfunction
endpackage

// File: rtl/ssp_sck_gen.sv
`timescale 1ns/1ps
module ssp_sck_gen #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             run,
  input  logic [SEL_W-1:0] half_m1,
  output logic             sck,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [SEL_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && !kick && (cnt == half_m1);
  assign rise_evt = wrap && !sck;
  assign fall_evt = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b1;
      cnt <= '0;
    end else if (kick) begin
      sck <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      if (cnt == half_m1) begin
        sck <= ~sck;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssp_in_sync.sv
`timescale 1ns/1ps
module ssp_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic din_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic din_s
);
  logic [STAGES-1:0] sck_sh;
  logic [STAGES-1:0] din_sh;
  logic              sck_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_sh <= '1;
          din_sh <= '0;
        end else begin
          sck_sh <= sck_raw;
          din_sh <= din_raw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_sh <= '1;
          din_sh <= '0;
        end else begin
          sck_sh <= {sck_sh[STAGES-2:0], sck_raw};
          din_sh <= {din_sh[STAGES-2:0], din_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_sh[STAGES-1];
  end

  assign sck_rise = sck_sh[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_sh[STAGES-1] & sck_prev;
  assign din_s    = din_sh[STAGES-1];
endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SW          = 8,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slave,
  input  logic             cfg_msb_first,
  input  logic             cfg_wide,
  input  logic [SEL_W-1:0] cfg_div,
  input  logic [DW-1:0]    tx_data,
  input  logic             start,
  output logic [DW-1:0]    rx_data,
  output logic             busy,
  output logic             done,
  output logic             sck_out,
  input  logic             sck_in,
  input  logic             sin,
  output logic             sout
);
  localparam idx_t LONG_LAST  = idx_t'(DW - 1);
  localparam idx_t SHORT_LAST = idx_t'(SW - 1);

  function automatic logic get_bit(input logic [DW-1:0] v, input idx_t pos);
    logic b;
    b = 1'b0;
    for (int i = 0; i < DW; i++) if (pos == idx_t'(i)) b = v[i];
    return b;
  endfunction

  function automatic logic [DW-1:0] set_bit(input logic [DW-1:0] v, input idx_t pos, input logic b);
    logic [DW-1:0] r;
    r = v;
    for (int i = 0; i < DW; i++) if (pos == idx_t'(i)) r[i] = b;
    return r;
  endfunction

  // Frame configuration captured at start
  logic             lat_slave;
  logic             lat_msb;
  idx_t             last_q;
  logic [SEL_W-1:0] div_q;
  logic [DW-1:0]    tx_q;
  logic [DW-1:0]    rx_acc;
  idx_t             bit_cnt;

  // Named internal events
  logic          accept;
  logic          gen_rise, gen_fall;
  logic          syn_rise, syn_fall, sin_s;
  logic          samp_evt, shift_evt, last_evt, samp_bit;
  logic          frame_long;
  idx_t          new_last;
  logic [DW-1:0] rx_next;

  assign accept     = start & ~busy;
  assign new_last   = frame_last(cfg_wide, SHORT_LAST, LONG_LAST);
  assign frame_long = (last_q == LONG_LAST);

  ssp_sck_gen #(.SEL_W(SEL_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (accept & ~cfg_slave),
    .run      (busy & ~lat_slave),
    .half_m1  (div_q),
    .sck      (sck_out),
    .rise_evt (gen_rise),
    .fall_evt (gen_fall)
  );

  ssp_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_raw  (sck_in),
    .din_raw  (sin),
    .sck_rise (syn_rise),
    .sck_fall (syn_fall),
    .din_s    (sin_s)
  );

  assign samp_evt  = busy & (lat_slave ? syn_rise : gen_rise);
  assign shift_evt = busy & (lat_slave ? syn_fall : gen_fall);
  assign samp_bit  = lat_slave ? sin_s : sin;
  assign last_evt  = samp_evt & (bit_cnt == last_q);
  assign rx_next   = set_bit(rx_acc, wire_pos(bit_cnt, lat_msb, last_q), samp_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_slave <= 1'b0;
      lat_msb   <= 1'b0;
      last_q    <= SHORT_LAST;
      div_q     <= '0;
      tx_q      <= '0;
      rx_acc    <= '0;
      rx_data   <= '0;
      bit_cnt   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      sout      <= 1'b1;
    end else begin
      done <= 1'b0;
      if (accept) begin
        lat_slave <= cfg_slave;
        lat_msb   <= cfg_msb_first;
        last_q    <= new_last;
        div_q     <= cfg_div;
        tx_q      <= tx_data;
        rx_acc    <= '0;
        bit_cnt   <= '0;
        busy      <= 1'b1;
        sout      <= get_bit(tx_data, wire_pos('0, cfg_msb_first, new_last));
      end else if (busy) begin
        if (shift_evt) sout <= get_bit(tx_q, wire_pos(bit_cnt, lat_msb, last_q));
        if (samp_evt) begin
          rx_acc  <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (last_evt) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_data <= rx_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssp_chk.sv
`timescale 1ns/1ps
module ssp_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sck_out,
  input logic          sout,
  input logic          lat_slave,
  input logic          frame_long,
  input logic [DW-1:0] rx_data
);
  // R2
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_long) |-> (rx_data[DW-1:SW] == '0));

  // R4
  sout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !lat_slave && !$fell(sck_out)) |-> $stable(sout));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(frame_long) && $stable(lat_slave)));

  // R9
  follower_sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_slave) |-> sck_out);
endmodule

bind sync_shift_port ssp_chk #(.DW(DW), .SW(SW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .sck_out    (sck_out),
  .sout       (sout),
  .lat_slave  (lat_slave),
  .frame_long (frame_long),
  .rx_data    (rx_data)
);

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_slave = 1'b0, cfg_msb_first = 1'b0, cfg_wide = 1'b0;
  logic [3:0]  cfg_div = 4'd0;
  logic [15:0] tx_data = 16'h0;
  logic        start = 1'b0;
  logic [15:0] rx_data;
  logic        busy, done, sck_out, sout;
  logic        sck_in = 1'b1;
  logic        sin = 1'b0;

  always #2.5 clk = ~clk;

  sync_shift_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_msb_first(cfg_msb_first),
    .cfg_wide(cfg_wide), .cfg_div(cfg_div), .tx_data(tx_data), .start(start),
    .rx_data(rx_data), .busy(busy), .done(done), .sck_out(sck_out),
    .sck_in(sck_in), .sin(sin), .sout(sout)
  );

  int checks = 0, fails = 0;
  bit finished = 0, done_seen = 0, slave_run = 0;
  logic [15:0] pat = 16'h0;

  // behavioural reference state (clock-owner mode)
  int m_busy = 0, m_sck = 1, m_ph = 0, m_nr = 0, m_len = 8, m_h = 1, m_done = 0, m_msb = 0;
  logic [15:0] m_tx = 16'h0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit nth_bit(input logic [15:0] v, input int msb, input int len, input int i);
    int p;
    p = msb ? (len - 1 - i) : i;
    return v[p];
  endfunction

  // cycle-by-cycle reference, evaluated 1 ns after each rising edge
  initial forever begin
    @(posedge clk); #1;
    if (!rst_n) begin
      m_busy = 0; m_sck = 1; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start && !cfg_slave) begin
          m_busy = 1; m_sck = 0; m_ph = 0; m_nr = 0;
          m_len = cfg_wide ? 16 : 8; m_h = int'(cfg_div) + 1;
          m_msb = cfg_msb_first; m_tx = tx_data;
          sin = nth_bit(pat, m_msb, m_len, 0);
        end
      end else begin
        m_ph++;
        if (m_ph == m_h) begin
          m_ph = 0;
          m_sck = !m_sck;
          if (m_sck == 1) begin
            // R4: bit on the wire at this rising edge
            chk(sout == nth_bit(m_tx, m_msb, m_len, m_nr), "R4", sout, nth_bit(m_tx, m_msb, m_len, m_nr));
            m_nr++;
            if (m_nr == m_len) begin
              m_busy = 0; m_done = 1;   // R3: frame ends after m_len rises
            end else begin
              sin = nth_bit(pat, m_msb, m_len, m_nr);
            end
          end
        end
      end
      chk(sck_out == m_sck[0], "R2", sck_out, m_sck);
      if (!slave_run) begin
        chk(busy == m_busy[0], "R6 busy", busy, m_busy);
        chk(done == m_done[0], "R6 done", done, m_done);
      end
      if (done) done_seen = 1;
    end
  end

  task automatic run_master(input int div, input bit msb, input bit wide,
                            input logic [15:0] tx, input logic [15:0] p, input bit poke);
    logic [15:0] exp;
    @(negedge clk);
    cfg_slave = 0; cfg_msb_first = msb; cfg_wide = wide; cfg_div = 4'(div);
    tx_data = tx; pat = p; done_seen = 0; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R7 R8: request with new data and flipped configuration mid-frame
      repeat (5) @(negedge clk);
      start = 1; tx_data = ~tx; cfg_wide = !wide; cfg_msb_first = !msb; cfg_div = 4'd0;
      @(negedge clk);
      start = 0;
    end
    for (int k = 0; k < 2000 && !done_seen; k++) @(negedge clk);
    chk(done_seen, "R6 done seen", done_seen, 1);
    exp = wide ? p : (p & 16'h00FF);
    chk(rx_data == exp, wide ? "R5 R3 wide" : "R5 R3 short", rx_data, exp);
    repeat (3) @(negedge clk);
    chk(busy == 0 && sck_out == 1, "R7 no restart", {busy, sck_out}, 1);
  endtask

  task automatic run_slave(input bit msb, input bit wide, input logic [15:0] tx, input logic [15:0] p);
    int len;
    logic [15:0] exp;
    len = wide ? 16 : 8;
    @(negedge clk);
    slave_run = 1; cfg_slave = 1; cfg_msb_first = msb; cfg_wide = wide;
    tx_data = tx; done_seen = 0; sck_in = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R9 armed", busy, 1);
    for (int i = 0; i < len; i++) begin
      sck_in = 0; sin = nth_bit(p, msb, len, i);
      repeat (6) @(negedge clk);
      chk(sout == nth_bit(tx, msb, len, i), "R9 R4 sout", sout, nth_bit(tx, msb, len, i));
      chk(sck_out == 1, "R9 sck_out idle", sck_out, 1);
      sck_in = 1;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(done_seen, "R9 done", done_seen, 1);
    exp = wide ? p : (p & 16'h00FF);
    chk(rx_data == exp, "R9 R5 rx", rx_data, exp);
    chk(busy == 0, "R9 idle", busy, 0);
    cfg_slave = 0; slave_run = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sck_out == 1 && sout == 1, "R1 lines", {sck_out, sout}, 3);
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(rx_data == 16'h0, "R1 rx", rx_data, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_master(0, 0, 0, 16'h00A5, 16'h003C, 0);
    run_master(3, 1, 1, 16'hC3A5, 16'h9E61, 0);
    run_master(1, 1, 0, 16'h005A, 16'h0081, 1);
    run_master(2, 0, 1, 16'h8001, 16'h7FFE, 0);
    run_slave(1, 0, 16'h0096, 16'h004B);
    run_slave(0, 1, 16'hF00D, 16'h1357);
    run_master(15, 0, 0, 16'hFF3C, 16'hFFFF, 0);   // R5: upper byte zero
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule